// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device side of a serial flash read path. It sits behind an SPI mode 0 slave port, takes a one-byte opcode and a three-byte address from the host, and streams bytes from a small synthesizable model of the main array back on the serial output. Two read commands are served. The continuous read (opcode 0x03) starts driving data right after the address. The page read (opcode 0xD2) first absorbs four filler bytes. The host ends either read at any point by releasing chip select.

The serial pins are oversampled by a system clock. SCK, CS and SI pass through two-flop synchronizers, and the edges of the synchronized SCK drive the sequencing. A static configuration input selects how the 24-bit address is split into page and byte offset. With 264-byte pages the low bits hold a 9-bit offset under an 11-bit page field. With 256-byte pages the address is a plain binary byte address. The array holds `2**PAGE_W` pages, and only the low `PAGE_W` bits of the page field are used. Array content is produced by a fixed formula, so the block needs no storage.

Top module: `flash_read_responder`

## Requirements
- R1: SI is sampled on rising SCK, MSB first, and SO changes only on falling SCK. After opcode 0x03 and three address bytes, the first data bit (MSB) is driven on the falling edge that follows the last address bit, and `soOe` rises at that edge.
- R2: After opcode 0xD2, three address bytes and four don't-care bytes are taken before the first data bit is driven on the next falling edge.
- R3: With `pageMode264`=1, address bits [8:0] give the byte offset and bits [9 +: PAGE_W] give the page. Higher page bits are ignored.
- R4: With `pageMode264`=0, address bits [7:0] give the byte offset and bits [8 +: PAGE_W] give the page.
- R5: A continuous read that passes the last offset of a page (263 or 255) goes on at offset 0 of the next page with no gap.
- R6: A continuous read that passes the last offset of the last page goes on at offset 0 of page 0.
- R7: In 264-byte mode, a starting offset of 264 or more is clamped to 263.
- R8: Within four system clocks of CS going high, `soOe` is 0, whatever phase the transfer was in. The next CS low starts a fresh opcode.
- R9: After any opcode other than 0x03 or 0xD2, `soOe` stays 0 until CS goes high.
- R10: The byte at page p, offset o equals o[7:0] XOR (37·p mod 256), further XORed with 0xA5 when o ≥ 256.
- R11: A page read (0xD2) that passes the last offset of its page continues at offset 0 of the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| pageMode264 | input | 1 | 1 = 264-byte pages with split address, 0 = 256-byte binary address |
| csN | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, mode 0 |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host, meaningful only when soOe is 1 |
| soOe | output | 1 | Output enable for SO; 0 means high impedance |

## Verification
Two events can coincide at the last byte of the last page: the page roll-over and the end-of-array wrap. They are provoked in both page modes by starting a read two bytes before the end of page 7. The check is that the byte after offset 263 (or 255) of page 7 is offset 0 of page 0, not offset 0 of a non-existent page 8. A second collision comes from releasing CS in the middle of a data byte, right after a falling edge has shifted a bit out. The judgement is that the output enable drops and that the following opcode is decoded from its first bit.

// File: rtl/frr_pkg.sv
package frr_pkg;
  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_IGNORE
  } frrState_t;

  typedef struct packed {
    logic shiftIn;   // take one SI bit
    logic capAddr;   // append received byte to address
    logic loadPtr;   // decode address into read pointer
    logic loadOut;   // fetch byte at pointer and advance
    logic shiftOut;  // shift next bit onto SO
    logic samePage;  // pointer wraps inside its page
  } dpCtrl_t;

  localparam logic [7:0] OPC_CONT = 8'h03;
  localparam logic [7:0] OPC_PAGE = 8'hD2;
endpackage

// File: rtl/frr_datapath.sv
module frr_datapath
  import frr_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pageMode264,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  dpCtrl_t    ctl,
  output logic       sckRise,
  output logic       sckFall,
  output logic       csHigh,
  output logic [7:0] rxByte,
  output logic       so
);
  localparam logic [8:0] LAST264 = 9'd263;
  localparam logic [8:0] LAST256 = 9'd255;

  logic [1:0]        sckSync, csSync, siSync;
  logic              sckPrev;
  logic [6:0]        inShift;
  logic [23:0]       addr, addrEff;
  logic [PAGE_W-1:0] ptrPage, decPage;
  logic [8:0]        ptrOff, decOff, lastOff;
  logic [7:0]        outShift;

  function automatic logic [7:0] arrayByte(input logic [PAGE_W-1:0] pg, input logic [8:0] off);
    logic [15:0] prod;
    prod = 16'(pg) * 16'd37;
    return off[7:0] ^ prod[7:0] ^ (off[8] ? 8'hA5 : 8'h00);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= 2'b00;
      csSync  <= 2'b11;
      siSync  <= 2'b00;
      sckPrev <= 1'b0;
    end else begin
      sckSync <= {sckSync[0], sck};
      csSync  <= {csSync[0], csN};
      siSync  <= {siSync[0], si};
      sckPrev <= sckSync[1];
    end
  end

  assign sckRise = sckSync[1] & ~sckPrev;
  assign sckFall = ~sckSync[1] & sckPrev;
  assign csHigh  = csSync[1];
  assign rxByte  = {inShift, siSync[1]};

  assign addrEff = ctl.capAddr ? {addr[15:0], rxByte} : addr;
  assign lastOff = pageMode264 ? LAST264 : LAST256;

  always_comb begin
    if (pageMode264) begin
      decPage = addrEff[9 +: PAGE_W];
      decOff  = (addrEff[8:0] > LAST264) ? LAST264 : addrEff[8:0];
    end else begin
      decPage = addrEff[8 +: PAGE_W];
      decOff  = {1'b0, addrEff[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      addr     <= '0;
      ptrPage  <= '0;
      ptrOff   <= '0;
      outShift <= '0;
    end else begin
      if (ctl.shiftIn) inShift <= rxByte[6:0];
      if (ctl.capAddr) addr <= addrEff;
      if (ctl.loadPtr) begin
        ptrPage <= decPage;
        ptrOff  <= decOff;
      end else if (ctl.loadOut) begin
        outShift <= arrayByte(ptrPage, ptrOff);
        if (ptrOff >= lastOff) begin
          ptrOff <= '0;
          if (!ctl.samePage) ptrPage <= ptrPage + 1'b1;
        end else begin
          ptrOff <= ptrOff + 1'b1;
        end
      end else if (ctl.shiftOut) begin
        outShift <= {outShift[6:0], 1'b0};
      end
    end
  end

  assign so = outShift[7];

  assert_off_in_page_R7: assert property (@(posedge clk) disable iff (!rstN)
    pageMode264 |-> (ptrOff <= LAST264));
  assert_out_on_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadOut || ctl.shiftOut) |-> sckFall);
  assert_in_on_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftIn |-> sckRise);
endmodule

// File: rtl/frr_control.sv
module frr_control
  import frr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       csHigh,
  input  logic [7:0] rxByte,
  output dpCtrl_t    ctl,
  output logic       soOe
);
  frrState_t  state;
  logic [2:0] bitCnt;
  logic [1:0] byteCnt;
  logic       isPageRd, dataLive, byteDone;

  assign byteDone = sckRise & ~csHigh & (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OPC;
      bitCnt   <= '0;
      byteCnt  <= '0;
      isPageRd <= 1'b0;
      dataLive <= 1'b0;
    end else if (csHigh) begin
      state    <= ST_OPC;
      bitCnt   <= '0;
      byteCnt  <= '0;
      dataLive <= 1'b0;
    end else if (sckRise) begin
      bitCnt <= bitCnt + 1'b1;
      if (byteDone) begin
        unique case (state)
          ST_OPC: begin
            byteCnt <= '0;
            if (rxByte == OPC_CONT) begin
              isPageRd <= 1'b0;
              state    <= ST_ADDR;
            end else if (rxByte == OPC_PAGE) begin
              isPageRd <= 1'b1;
              state    <= ST_ADDR;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ADDR: begin
            if (byteCnt == 2'd2) begin
              byteCnt <= '0;
              state   <= isPageRd ? ST_DUMMY : ST_DATA;
            end else begin
              byteCnt <= byteCnt + 1'b1;
            end
          end
          ST_DUMMY: begin
            if (byteCnt == 2'd3) begin
              byteCnt <= '0;
              state   <= ST_DATA;
            end else begin
              byteCnt <= byteCnt + 1'b1;
            end
          end
          default: state <= state;
        endcase
      end
    end else if (sckFall && state == ST_DATA && bitCnt == 3'd0) begin
      dataLive <= 1'b1;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.shiftIn  = sckRise & ~csHigh;
    ctl.capAddr  = byteDone & (state == ST_ADDR);
    ctl.loadPtr  = byteDone & (((state == ST_ADDR) & (byteCnt == 2'd2) & ~isPageRd) |
                               ((state == ST_DUMMY) & (byteCnt == 2'd3)));
    ctl.loadOut  = sckFall & ~csHigh & (state == ST_DATA) & (bitCnt == 3'd0);
    ctl.shiftOut = sckFall & ~csHigh & (state == ST_DATA) & (bitCnt != 3'd0);
    ctl.samePage = isPageRd;
  end

  assign soOe = dataLive;

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !soOe);
  assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !soOe);
  assert_enable_on_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soOe) |-> $past(ctl.loadOut));
  assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadPtr, ctl.loadOut, ctl.shiftOut}));
endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
  import frr_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pageMode264,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic soOe
);
  dpCtrl_t    ctl;
  logic       sckRise, sckFall, csHigh;
  logic [7:0] rxByte;

  frr_datapath #(.PAGE_W(PAGE_W)) i_datapath (
    .clk(clk), .rstN(rstN), .pageMode264(pageMode264),
    .csN(csN), .sck(sck), .si(si), .ctl(ctl),
    .sckRise(sckRise), .sckFall(sckFall), .csHigh(csHigh),
    .rxByte(rxByte), .so(so)
  );

  frr_control i_control (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csHigh(csHigh), .rxByte(rxByte), .ctl(ctl), .soOe(soOe)
  );
endmodule

// File: tb/test_flash_read_responder.sv
module test_flash_read_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int PAGE_W = 3;
  localparam int NPAGES = 1 << PAGE_W;

  logic clk = 0, rstN = 0, pageMode264 = 1, csN = 1, sck = 0, si = 0;
  logic so, soOe;
  int checks = 0, errors = 0;

  flash_read_responder #(.PAGE_W(PAGE_W)) i_flash_read_responder (
    .clk(clk), .rstN(rstN), .pageMode264(pageMode264), .csN(csN),
    .sck(sck), .si(si), .so(so), .soOe(soOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] expByte(input int pg, input int off);
    logic [7:0] v;
    v = 8'(off) ^ 8'(pg * 37);
    if (off >= 256) v = v ^ 8'hA5;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      waitClk(HALF); sck = 1;
      waitClk(HALF); sck = 0;
    end
  endtask

  task automatic readByte(output logic [7:0] b, output logic oeAll, output logic oeAny);
    oeAll = 1; oeAny = 0;
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF);
      b[i] = so; oeAll &= soOe; oeAny |= soOe;
      sck = 1; waitClk(HALF); sck = 0;
    end
  endtask

  task automatic endCmd();
    waitClk(2); csN = 1; waitClk(10);
  endtask

  task automatic startRead(input logic [7:0] op, input logic [23:0] addr);
    waitClk(2); csN = 0; waitClk(2);
    sendByte(op);
    sendByte(addr[23:16]); sendByte(addr[15:8]); sendByte(addr[7:0]);
    if (op == 8'hD2) for (int d = 0; d < 4; d++) sendByte(8'h5C);
  endtask

  // reads n bytes and compares with the model pointer walk
  task automatic readExpect(input string req, input int n, input int pg0, input int off0,
                            input bit samePg);
    int pg = pg0, off = off0, last;
    logic [7:0] b; logic oeAll, oeAny;
    last = pageMode264 ? 263 : 255;
    for (int k = 0; k < n; k++) begin
      readByte(b, oeAll, oeAny);
      check(req, b, expByte(pg, off));
      check({req, " oe"}, oeAll, 1'b1);
      if (off == last) begin
        off = 0;
        if (!samePg) pg = (pg + 1) % NPAGES;
      end else off++;
    end
  endtask

  task automatic testReset();
    check("R8 reset oe", soOe, 1'b0);
  endtask

  task automatic testCont264();
    pageMode264 = 1;
    startRead(8'h03, (24'd10 << 9) | 24'd5);   // page 10 -> 2 (R3 upper bits ignored)
    readExpect("R1 R3 R10 cont264", 4, 2, 5, 0);
    endCmd();
  endtask

  task automatic testCont256Cross();
    pageMode264 = 0;
    startRead(8'h03, (24'd3 << 8) | 24'd253);
    readExpect("R4 R5 cont256 cross", 5, 3, 253, 0);
    endCmd();
  endtask

  task automatic testCross264();
    pageMode264 = 1;
    startRead(8'h03, (24'd1 << 9) | 24'd261);
    readExpect("R5 R10 cross264", 4, 1, 261, 0);
    endCmd();
  endtask

  task automatic testWrap();
    pageMode264 = 1;
    startRead(8'h03, (24'(NPAGES - 1) << 9) | 24'd262);
    readExpect("R6 wrap264", 3, NPAGES - 1, 262, 0);
    endCmd();
    pageMode264 = 0;
    startRead(8'h03, (24'(NPAGES - 1) << 8) | 24'd254);
    readExpect("R6 wrap256", 3, NPAGES - 1, 254, 0);
    endCmd();
  endtask

  task automatic testPageRead();
    pageMode264 = 0;
    startRead(8'hD2, (24'd5 << 8) | 24'd254);
    readExpect("R2 R11 pageread256", 4, 5, 254, 1);
    endCmd();
    pageMode264 = 1;
    startRead(8'hD2, (24'd4 << 9) | 24'd262);
    readExpect("R2 R11 pageread264", 3, 4, 262, 1);
    endCmd();
  endtask

  task automatic testClamp();
    pageMode264 = 1;
    startRead(8'h03, (24'd6 << 9) | 24'd300);
    readExpect("R7 clamp", 2, 6, 263, 0);
    endCmd();
  endtask

  task automatic testUnknown();
    logic [7:0] b; logic oeAll, oeAny;
    pageMode264 = 1;
    startRead(8'h0B, 24'h000105);
    for (int k = 0; k < 3; k++) begin
      readByte(b, oeAll, oeAny);
      check("R9 unknown opcode oe", oeAny, 1'b0);
    end
    endCmd();
  endtask

  task automatic testRelease();
    logic [7:0] b; logic oeAll, oeAny;
    pageMode264 = 0;
    startRead(8'h03, (24'd2 << 8) | 24'd7);
    readByte(b, oeAll, oeAny);
    check("R8 before release", b, expByte(2, 7));
    // mid-byte: three bits out, then release right after a falling edge
    for (int i = 0; i < 3; i++) begin
      waitClk(HALF); sck = 1; waitClk(HALF); sck = 0;
    end
    check("R8 oe before release", soOe, 1'b1);
    csN = 1; waitClk(5);
    check("R8 oe after release", soOe, 1'b0);
    waitClk(5);
    startRead(8'h03, (24'd4 << 8) | 24'd9);
    readExpect("R8 fresh command", 2, 4, 9, 0);
    endCmd();
  endtask

  initial begin
    waitClk(5); rstN = 1; waitClk(5);
    testReset();
    testCont264();
    testCont256Cross();
    testCross264();
    testWrap();
    testPageRead();
    testClamp();
    testUnknown();
    testRelease();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule